// File: doc/BRIEF.md
# Programmable Tick Timer with Prescaler

This block is an 8-bit up-counter for a microcontroller subsystem. Software loads and reads it through a small register port. It has two count sources. In timer mode it advances on each cycle in which the instruction-cycle strobe is high. In counter mode it counts edges on an asynchronous external pin, and software picks whether rising or falling edges count. An optional divider sits between the source and the counter. The divider is programmed in powers of two from 1:2 to 1:256 and can be bypassed.

When the count wraps from FFh to 00h, a sticky overflow flag is set, and software clears it. The interrupt output is this flag gated by an enable bit in the control register. After software writes the count, the next two source ticks are swallowed, so a loaded value holds for a predictable time. The reset input is asserted asynchronously and released synchronously inside the block.

Control register layout, used throughout: bit 0 selects the source (0 = strobe, 1 = external pin). Bit 1 selects the edge (0 = rising, 1 = falling). Bit 2 bypasses the divider when set. Bits 5:3 hold the ratio code n. Bit 6 enables the interrupt. Bit 7 is reserved.

Top module: `cyc_timer8`

## Requirements
- R1: Two cycles after the reset input is released, the count reads 00h, the flag and interrupt are low, and the control register reads 04h (strobe source, divider bypassed, interrupt disabled).
- R2: In strobe mode with the divider bypassed, the count rises by one on each clock in which `tick_en_i` is high, stays put otherwise, and wraps modulo 256.
- R3: An advance from FFh to 00h sets `ovf_flag_o`. The flag stays set until a cycle with `ovf_clr_i` high clears it. If a wrap and a clear fall in the same cycle, the flag ends up set.
- R4: `irq_o` is high exactly when the flag is set and control bit 6 is 1.
- R5: A pulse on `wr_cnt_i` loads `cnt_wdata_i` into the count on the next clock edge and clears the divider. An advance in the same cycle is lost. The next two source ticks after the write are discarded.
- R6: With control bit 2 at 0 and ratio code n in bits 5:3, the count advances once per 2^(n+1) accepted source ticks, counted from the last count write.
- R7: With control bit 0 at 1, `tick_en_i` is ignored and each selected edge of `ext_clk_i` is one source tick (bit 1 = 0 counts rising edges, 1 counts falling edges). Each edge passes two synchronizer flops, so the count changes on the third clock edge that samples the new pin level.
- R8: `ctl_o` returns bits 6:0 of the last control write, and bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Instruction-cycle strobe, used as the source in timer mode |
| ext_clk_i | input | 1 | Asynchronous external count input |
| wr_cnt_i | input | 1 | Count register write strobe |
| cnt_wdata_i | input | 8 | Value to load into the count |
| wr_ctl_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Value to write into the control register |
| ovf_clr_i | input | 1 | Software clear of the overflow flag |
| cnt_o | output | 8 | Current count |
| ctl_o | output | 8 | Control register read-back |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Flag gated by the interrupt enable |

## Verification
Two things can land in one cycle: the counter's own wrap and the software actions aimed at it. The bench loads FFh and then raises the clear strobe in exactly the cycle of the wrapping tick; the flag must end up set. It also pulses a count write in a cycle where a tick arrives; the written value must win and the two ticks after it must be swallowed. A constrained-random phase then mixes writes, clears and ticks freely. A cycle-level reference model built from the requirements judges every cycle of that phase.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
  localparam int CTL_W   = 8;
  localparam int RATIO_W = 3;

  typedef struct packed {
    logic               rsvd;
    logic               irq_en;
    logic [RATIO_W-1:0] ratio;
    logic               bypass;
    logic               edge_fall;
    logic               src_ext;
  } ctl_t;

  localparam ctl_t CTL_RST = '{rsvd: 1'b0, irq_en: 1'b0, ratio: '0,
                               bypass: 1'b1, edge_fall: 1'b0, src_ext: 1'b0};
endpackage

// File: rtl/ctimer_rst_sync.sv
module ctimer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sh_q <= '0;
    else          sh_q <= sh_d;
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/ctimer_src_sel.sv
module ctimer_src_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic tick_en_i,
  input  logic src_ext_i,
  input  logic edge_fall_i,
  output logic src_tick_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   level, rise, fall, ext_tick;

  always_comb begin
    sync_d   = {sync_q[SYNC_STAGES-2:0], ext_i};
    level    = sync_q[SYNC_STAGES-1];
    prev_d   = level;
    rise     = level & ~prev_q;
    fall     = ~level & prev_q;
    ext_tick = edge_fall_i ? fall : rise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  generate
    if (SYNC_STAGES < 2) begin : g_bad
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  assign src_tick_o = src_ext_i ? ext_tick : tick_en_i;
endmodule

// File: rtl/ctimer_prescale.sv
module ctimer_prescale
  import ctimer_pkg::*;
#(
  parameter int PSC_W         = 8,
  parameter int INHIBIT_TICKS = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               src_tick_i,
  input  logic               load_i,
  input  logic               bypass_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               adv_o
);
  localparam int INH_W = $clog2(INHIBIT_TICKS + 1);
  localparam logic [INH_W-1:0] INH_LOAD = INH_W'(INHIBIT_TICKS);

  logic [INH_W-1:0] inh_q, inh_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [PSC_W:0]   full_span;
  logic [PSC_W-1:0] mask;
  logic             gated, hit;

  always_comb begin
    full_span = ((PSC_W+1)'(1) << ({1'b0, ratio_i} + 1'b1)) - (PSC_W+1)'(1);
    mask      = full_span[PSC_W-1:0];
    gated     = src_tick_i && (inh_q == '0) && !load_i;
    hit       = (psc_q & mask) == mask;
    adv_o     = gated && (bypass_i || hit);

    if (load_i)                              inh_d = INH_LOAD;
    else if (src_tick_i && (inh_q != '0))    inh_d = inh_q - 1'b1;
    else                                     inh_d = inh_q;

    if (load_i)                  psc_d = '0;
    else if (gated && !bypass_i) psc_d = hit ? '0 : psc_q + 1'b1;
    else                         psc_d = psc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inh_q <= '0;
      psc_q <= '0;
    end else begin
      inh_q <= inh_d;
      psc_q <= psc_d;
    end
  end
endmodule

// File: rtl/cyc_timer8.sv
module cyc_timer8
  import ctimer_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int PSC_W         = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int RST_STAGES    = 2,
  parameter int INHIBIT_TICKS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             ext_clk_i,
  input  logic             wr_cnt_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             wr_ctl_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             ovf_flag_o,
  output logic             irq_o
);
  logic             rst_n_int;
  logic             src_tick, adv, wrap;
  ctl_t             ctl_q, ctl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;

  ctimer_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n_int)
  );

  ctimer_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .ext_i       (ext_clk_i),
    .tick_en_i   (tick_en_i),
    .src_ext_i   (ctl_q.src_ext),
    .edge_fall_i (ctl_q.edge_fall),
    .src_tick_o  (src_tick)
  );

  ctimer_prescale #(.PSC_W(PSC_W), .INHIBIT_TICKS(INHIBIT_TICKS)) u_psc (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .src_tick_i (src_tick),
    .load_i     (wr_cnt_i),
    .bypass_i   (ctl_q.bypass),
    .ratio_i    (ctl_q.ratio),
    .adv_o      (adv)
  );

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl_i) begin
      ctl_d      = ctl_t'(ctl_wdata_i);
      ctl_d.rsvd = 1'b0;
    end

    wrap = adv && !wr_cnt_i && (cnt_q == '1);

    if (wr_cnt_i) cnt_d = cnt_wdata_i;
    else if (adv) cnt_d = cnt_q + 1'b1;
    else          cnt_d = cnt_q;

    if (wrap)           flag_d = 1'b1;
    else if (ovf_clr_i) flag_d = 1'b0;
    else                flag_d = flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ctl_q  <= CTL_RST;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign ctl_o      = ctl_q;
  assign ovf_flag_o = flag_q;
  assign irq_o      = flag_q & ctl_q.irq_en;
endmodule

// File: rtl/ctimer_chk.sv
module ctimer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_cnt_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic             ovf_clr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [7:0]       ctl_o,
  input logic             ovf_flag_o,
  input logic             irq_o
);
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_i |=> (cnt_o == $past(cnt_wdata_i)));

  p_first_tick_swallowed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_cnt_i) && !wr_cnt_i) |=> $stable(cnt_o));

  p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt_i |=> ((cnt_o == $past(cnt_o)) || (cnt_o == CNT_W'($past(cnt_o) + 1'b1))));

  p_wrap_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_o == '1) && !wr_cnt_i) ##1 (cnt_o == '0) |-> ovf_flag_o);

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);

  p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ovf_flag_o && ctl_o[6]));

  p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o[7] == 1'b0);
endmodule

bind cyc_timer8 ctimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk_i),
  .rst_n       (rst_n_int),
  .wr_cnt_i    (wr_cnt_i),
  .cnt_wdata_i (cnt_wdata_i),
  .ovf_clr_i   (ovf_clr_i),
  .cnt_o       (cnt_o),
  .ctl_o       (ctl_o),
  .ovf_flag_o  (ovf_flag_o),
  .irq_o       (irq_o)
);

// File: tb/tb_cyc_timer8.sv
module tb_cyc_timer8;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, ext_clk, wr_cnt, wr_ctl, ovf_clr;
  logic [7:0] cnt_wdata, ctl_wdata;
  logic [7:0] cnt, ctl;
  logic       flag, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model state
  logic [7:0] m_cnt, m_psc, m_ctl;
  int         m_inh;
  logic       m_flag, m_s0, m_s1, m_prev;
  logic       ext_lvl;

  always #10 clk = ~clk;

  cyc_timer8 dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en), .ext_clk_i(ext_clk),
    .wr_cnt_i(wr_cnt), .cnt_wdata_i(cnt_wdata), .wr_ctl_i(wr_ctl),
    .ctl_wdata_i(ctl_wdata), .ovf_clr_i(ovf_clr), .cnt_o(cnt), .ctl_o(ctl),
    .ovf_flag_o(flag), .irq_o(irq)
  );

  function automatic logic [7:0] div_mask(input logic [2:0] n);
    return 8'(((9'd1) << (n + 1)) - 9'd1);
  endfunction

  function automatic logic exp_irq(input logic f, input logic [7:0] c);
    return f & c[6];
  endfunction

  task automatic expect8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic expect1(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic tk, input logic wc, input logic [7:0] wd,
                     input logic wk, input logic [7:0] kd, input logic cl);
    logic       lvl, edg, src, gated, hit, adv;
    logic [7:0] n_cnt, n_psc, n_ctl;
    int         n_inh;
    logic       n_flag;
    @(negedge clk);
    tick_en = tk; ext_clk = ext_lvl; wr_cnt = wc; cnt_wdata = wd;
    wr_ctl = wk; ctl_wdata = kd; ovf_clr = cl;
    lvl   = m_s1;
    edg   = m_ctl[1] ? (~lvl & m_prev) : (lvl & ~m_prev);
    src   = m_ctl[0] ? edg : tk;
    gated = src && (m_inh == 0) && !wc;
    hit   = (m_psc & div_mask(m_ctl[5:3])) == div_mask(m_ctl[5:3]);
    adv   = gated && (m_ctl[2] || hit);
    n_inh = wc ? 2 : ((src && m_inh != 0) ? m_inh - 1 : m_inh);
    n_psc = wc ? 8'h00 : ((gated && !m_ctl[2]) ? (hit ? 8'h00 : m_psc + 8'h01) : m_psc);
    n_cnt = wc ? wd : (adv ? m_cnt + 8'h01 : m_cnt);
    n_flag = (adv && !wc && m_cnt == 8'hFF) ? 1'b1 : (cl ? 1'b0 : m_flag);
    n_ctl = wk ? {1'b0, kd[6:0]} : m_ctl;
    @(posedge clk);
    m_cnt = n_cnt; m_psc = n_psc; m_inh = n_inh; m_flag = n_flag; m_ctl = n_ctl;
    m_prev = m_s1; m_s1 = m_s0; m_s0 = ext_lvl;
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
  endtask
  task automatic wcnt(input logic [7:0] v);
    cyc(1'b0, 1'b1, v, 1'b0, 8'h00, 1'b0);
  endtask
  task automatic wctl(input logic [7:0] v);
    cyc(1'b0, 1'b0, 8'h00, 1'b1, v, 1'b0);
  endtask
  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      ext_lvl = 1'b1;
      for (int j = 0; j < 3; j++) cyc(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
      ext_lvl = 1'b0;
      for (int j = 0; j < 3; j++) cyc(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
    end
  endtask

  task automatic cmp_model(input string tag);
    expect8({tag, " cnt"}, cnt, m_cnt);
    expect1({tag, " flag"}, flag, m_flag);
    expect1({tag, " irq"}, irq, exp_irq(m_flag, m_ctl));
    expect8({tag, " ctl"}, ctl, m_ctl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; tick_en = 0; ext_clk = 0; wr_cnt = 0; wr_ctl = 0; ovf_clr = 0;
    cnt_wdata = 0; ctl_wdata = 0; ext_lvl = 0;
    m_cnt = 0; m_psc = 0; m_inh = 0; m_flag = 0; m_ctl = 8'h04;
    m_s0 = 0; m_s1 = 0; m_prev = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    expect8("R1 cnt", cnt, 8'h00);
    expect1("R1 flag", flag, 1'b0);
    expect1("R1 irq", irq, 1'b0);
    expect8("R1 ctl", ctl, 8'h04);

    // R2 counting on strobe, gaps hold
    ticks(5);
    expect8("R2 five ticks", cnt, 8'h05);
    idle(3);
    expect8("R2 no strobe hold", cnt, 8'h05);

    // R8 control read-back
    wctl(8'hFF);
    expect8("R8 readback", ctl, 8'h7F);
    wctl(8'h04);
    expect8("R8 restore", ctl, 8'h04);

    // R5 load and two swallowed ticks
    wcnt(8'h10);
    expect8("R5 load", cnt, 8'h10);
    ticks(2);
    expect8("R5 two ticks swallowed", cnt, 8'h10);
    ticks(1);
    expect8("R5 third tick counts", cnt, 8'h11);
    cyc(1'b1, 1'b1, 8'h20, 1'b0, 8'h00, 1'b0);
    expect8("R5 write beats tick", cnt, 8'h20);

    // R3 wrap, stickiness, clear
    wcnt(8'hFE);
    ticks(3);
    expect8("R3 at FF", cnt, 8'hFF);
    expect1("R3 no flag yet", flag, 1'b0);
    ticks(1);
    expect8("R3 wrapped", cnt, 8'h00);
    expect1("R3 flag set", flag, 1'b1);
    idle(3);
    expect1("R3 flag sticky", flag, 1'b1);
    // R4 gating
    expect1("R4 irq masked", irq, 1'b0);
    wctl(8'h44);
    expect1("R4 irq enabled", irq, 1'b1);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
    expect1("R3 flag cleared", flag, 1'b0);
    expect1("R4 irq drops", irq, 1'b0);
    // R3 wrap and clear in the same cycle
    wcnt(8'hFF);
    ticks(2);
    cyc(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
    expect8("R3 same-cycle cnt", cnt, 8'h00);
    expect1("R3 set beats clear", flag, 1'b1);
    cyc(1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);

    // R6 divider 1:4
    wctl(8'h08);
    wcnt(8'h00);
    ticks(2 + 3);
    expect8("R6 1:4 before", cnt, 8'h00);
    ticks(1);
    expect8("R6 1:4 first", cnt, 8'h01);
    ticks(4);
    expect8("R6 1:4 second", cnt, 8'h02);
    // R6 divider 1:256
    wctl(8'h38);
    wcnt(8'h00);
    ticks(2 + 255);
    expect8("R6 1:256 before", cnt, 8'h00);
    ticks(1);
    expect8("R6 1:256 first", cnt, 8'h01);

    // R7 rising edges, strobe ignored
    wctl(8'h05);
    wcnt(8'h00);
    pulse_ext(2);
    expect8("R7 two edges swallowed", cnt, 8'h00);
    pulse_ext(3);
    expect8("R7 rising count", cnt, 8'h03);
    // R7 latency: counted on third sampling edge
    ext_lvl = 1'b1;
    cyc(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
    cyc(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
    expect8("R7 not yet", cnt, 8'h03);
    cyc(1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0);
    expect8("R7 third edge", cnt, 8'h04);
    ext_lvl = 1'b0;
    idle(4);
    expect8("R7 falling ignored", cnt, 8'h04);
    // R7 falling edges
    wctl(8'h07);
    wcnt(8'h00);
    pulse_ext(5);
    expect8("R7 falling count", cnt, 8'h03);

    // constrained random against the model
    wctl(8'h04);
    for (int i = 0; i < 6000; i++) begin
      logic       tk, wc, wk, cl;
      logic [7:0] wd, kd;
      tk = ($urandom % 4) != 0;
      wc = ($urandom % 50) == 0;
      wd = 8'($urandom);
      wk = ($urandom % 80) == 0;
      kd = 8'($urandom) & 8'h4F;
      cl = ($urandom % 30) == 0;
      if (($urandom % 3) == 0) ext_lvl = ~ext_lvl;
      cyc(tk, wc, wd, wk, kd, cl);
      cmp_model("R2/R7 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule